// File: doc/BRIEF.md
# Self-Timed Power-On Reset Generator

This block makes the reset for a design that has no external reset pin. It relies only on whatever its own flip-flops hold at power-up. An 8-bit linear feedback shift register with XNOR feedback steps on every clock edge. While its value differs from a terminal pattern chosen at design time, the reset output stays asserted. When the register reaches that pattern, it freezes and the reset is released for good.

The terminal pattern has both zero and one bits. Because of that, neither a cleared nor a fully set register can release reset at power-up. The XNOR lockup value (all ones) is detected and pushed back into the sequence, so every start value reaches the terminal pattern. Both outputs come from flip-flops, so they can drive a global set/reset resource or a normal distributed reset tree without glitches.

Top module: `por_gen`

## Requirements
- R1: On each rising edge the register, when it is not at the terminal pattern and not all-ones, shifts left by one bit. Bit 0 takes the XNOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1).
- R2: From the all-ones lockup value, the register moves to 8'hFE on the next edge. Release from all-ones therefore takes exactly one edge more than release from 8'hFE.
- R3: After each rising edge, rst_o is 1 if the register value before that edge differed from the terminal pattern, and 0 otherwise.
- R4: Once the terminal pattern is reached the register holds it, and rst_o stays 0 on every later edge.
- R5: After the first edge, rst_no is always the complement of rst_o.
- R6: From any of the 256 start values, rst_o goes low within 256 rising edges.
- R7: The terminal pattern parameter (default 8'hA5) must hold both 0 and 1 bits, and elaboration stops otherwise. As a result, starting from 8'h00 or 8'hFF leaves rst_o at 1 after the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_o | output | 1 | Reset, active high, registered |
| rst_no | output | 1 | Reset, active low, registered |

## Verification
A register stepping with the wrong taps, escaping lockup to the wrong value, or failing to freeze shows up at the ports as a release on the wrong edge. For some start values the difference appears within a few cycles. For others it takes up to 256 edges, so every one of the 256 start values is loaded and its release edge is compared with an independent model. A missed freeze shows as rst_o rising again within one edge after release. A broken output register shows as a mismatch between rst_o and rst_no on the first edge after the fault.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned POR_W = 8;
  localparam logic [POR_W-1:0] POR_TAPS = 8'hB8;  // bits 7,5,4,3
  localparam logic [POR_W-1:0] POR_TERM = 8'hA5;

  function automatic logic term_ok(input logic [POR_W-1:0] t);
    return (t != '0) && (t != '1);
  endfunction
endpackage

// File: rtl/por_lfsr.sv
module por_lfsr #(
  parameter int unsigned W = por_pkg::POR_W,
  parameter logic [W-1:0] TAPS = por_pkg::POR_TAPS,
  parameter logic [W-1:0] TERM = por_pkg::POR_TERM
) (
  input  logic         clk_i,
  output logic [W-1:0] state_o,
  output logic         at_term_o
);
  localparam logic [W-1:0] LOCKUP = '1;
  localparam logic [W-1:0] ESCAPE = {{(W-1){1'b1}}, 1'b0};

  // no reset: power-up content is the start value
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  assign fb        = ~(^(state_q & TAPS));
  assign at_term_o = (state_q == TERM);
  assign state_o   = state_q;

  always_comb begin
    if (at_term_o)                state_d = state_q;
    else if (state_q == LOCKUP)   state_d = ESCAPE;
    else                          state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk_i) state_q <= state_d;
endmodule

// File: rtl/por_out.sv
module por_out (
  input  logic clk_i,
  input  logic at_term_i,
  output logic rst_o,
  output logic rst_no
);
  logic rst_q;
  logic rst_nq;

  // two separate flops so each tree gets a clean driver
  always_ff @(posedge clk_i) begin
    rst_q  <= ~at_term_i;
    rst_nq <= at_term_i;
  end

  assign rst_o  = rst_q;
  assign rst_no = rst_nq;
endmodule

// File: rtl/por_gen.sv
module por_gen #(
  parameter int unsigned W = por_pkg::POR_W,
  parameter logic [W-1:0] TAPS = por_pkg::POR_TAPS,
  parameter logic [W-1:0] TERM = por_pkg::POR_TERM
) (
  input  logic clk_i,
  output logic rst_o,
  output logic rst_no
);
  logic [W-1:0] state_w;
  logic         at_term_w;

  if ((TERM == '0) || (TERM == '1)) begin : g_bad_term
    $error("por_gen: terminal pattern needs both 0 and 1 bits");
  end

  por_lfsr #(.W(W), .TAPS(TAPS), .TERM(TERM)) u_state (
    .clk_i     (clk_i),
    .state_o   (state_w),
    .at_term_o (at_term_w)
  );

  por_out u_out (
    .clk_i     (clk_i),
    .at_term_i (at_term_w),
    .rst_o     (rst_o),
    .rst_no    (rst_no)
  );
endmodule

// File: rtl/por_gen_chk.sv
module por_gen_chk #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TERM = 8'hA5
) (
  input logic         clk_i,
  input logic [W-1:0] state_i,
  input logic         rst_o,
  input logic         rst_no
);
  logic [1:0] warm_q = '0;
  logic [9:0] hi_cnt_q = '0;
  logic       warm;

  assign warm = (warm_q == 2'd3);

  always_ff @(posedge clk_i) begin
    if (!warm) warm_q <= warm_q + 2'd1;
    if (!rst_o)                 hi_cnt_q <= '0;
    else if (hi_cnt_q != '1)    hi_cnt_q <= hi_cnt_q + 10'd1;
  end

  // R5
  outs_complement_chk: assert property (@(posedge clk_i) disable iff (!warm)
    rst_o != rst_no);

  // R2
  lockup_escape_chk: assert property (@(posedge clk_i) disable iff (!warm)
    (state_i == '1) |=> (state_i == {{(W-1){1'b1}}, 1'b0}));

  // R3
  release_from_term_chk: assert property (@(posedge clk_i) disable iff (!warm)
    $fell(rst_o) |-> ($past(state_i) == TERM));

  // R3
  assert_from_other_chk: assert property (@(posedge clk_i) disable iff (!warm)
    $rose(rst_o) |-> ($past(state_i) != TERM));

  // R6
  release_bound_chk: assert property (@(posedge clk_i) disable iff (!warm)
    hi_cnt_q <= 10'd256);
endmodule

bind por_gen por_gen_chk #(.W(W), .TERM(TERM)) u_chk (
  .clk_i   (clk_i),
  .state_i (state_w),
  .rst_o   (rst_o),
  .rst_no  (rst_no)
);

// File: tb/por_gen_tb_top.sv
module por_gen_tb_top;
  localparam logic [7:0] TERM = 8'hA5;

  logic clk = 1'b0;
  logic rst_o;
  logic rst_no;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  int   rel_tab [256];

  always #2 clk = ~clk;  // 250 MHz

  por_gen dut_i (.clk_i(clk), .rst_o(rst_o), .rst_no(rst_no));

  function automatic logic [7:0] model_next(input logic [7:0] v);
    if (v == TERM) return v;
    if (v == 8'hFF) return 8'hFE;
    return {v[6:0], ~(v[7] ^ v[5] ^ v[4] ^ v[3])};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_start(input int s);
    logic [7:0] m;
    bit exp;
    int rel;
    @(negedge clk);
    dut_i.u_state.state_q = 8'(s);
    m = 8'(s);
    rel = -1;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk);
      exp = (m != TERM);
      m = model_next(m);
      @(negedge clk);
      if (rel < 0) check(rst_o == exp, "R1 R3 rst_o", int'(rst_o), int'(exp));
      else         check(rst_o == 1'b0, "R4 stays released", int'(rst_o), 0);
      check(rst_no == !exp, "R5 rst_no", int'(rst_no), int'(!exp));
      if (k == 0 && (s == 0 || s == 255))
        check(rst_o == 1'b1, "R7 no early release", int'(rst_o), 1);
      if (!exp && rel < 0) rel = k + 1;
      if (rel > 0 && k >= rel + 7) break;
    end
    rel_tab[s] = rel;
    check(rel > 0 && rel <= 256, "R6 release bound", rel, 256);
  endtask

  initial begin
    for (int s = 0; s < 256; s++) run_start(s);
    check(rel_tab[255] == rel_tab[254] + 1, "R2 lockup escape",
          rel_tab[255], rel_tab[254] + 1);
    check(rel_tab[int'(TERM)] == 1, "R3 start at terminal", rel_tab[int'(TERM)], 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule